// File: doc/BRIEF.md
# Retriggerable LED Pulse Stretcher with Rhythm Generator

This block widens single-cycle internal strobes into LED indications long enough for a person to notice. Each strobe on the event input loads a stretch counter whose most significant bit both lights the LED and enables counting. While that bit is set the counter advances every clock. When it rolls over from all ones to zero, the bit clears and the counter stops. A strobe that arrives while the LED is lit reloads the counter, so a burst of strobes merges into one longer flash that ends a full interval after the last strobe.

Next to the stretch path, a free-running counter feeds a small set of blink patterns. Each pattern ANDs the counter's top bit with the top bit itself or with a lower bit. The patterns give a slow square blink, a double flash and a four-flash strobe, and these can mark an operating mode. Both counter widths are parameters. With the defaults (21 and 24 bits) and a 16 MHz clock, a flash lasts about 1/16 s and the slow blink runs at about 1 Hz. A bench can shrink the widths.

Top module: `ledPulseStretcher`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ledOut` is 0 and every bit of `rhythmOut` is 0. The stretch counter is held at zero and does not count.
- R2: An event sampled high at a clock edge sets `ledOut` to 1 from that edge onward. With no further event, `ledOut` stays 1 for exactly 2^(STRETCH_W-1) clock cycles.
- R3: Once the lit interval ends, `ledOut` returns to 0. It stays 0, and the counter holds at zero, until the next event.
- R4: An event sampled while `ledOut` is already 1 restarts the full interval of 2^(STRETCH_W-1) cycles, counted from that event.
- R5: An event sampled at the same edge on which the counter would roll over to zero takes priority. `ledOut` stays 1 with no gap, and a new full interval starts.
- R6: `rhythmOut[0]` equals bit RHYTHM_W-1 of a free-running count of clock edges since reset was released, taken modulo 2^RHYTHM_W. This is a square blink with a 50 % duty cycle.
- R7: `rhythmOut[1]` equals bit RHYTHM_W-1 AND bit RHYTHM_W-3 of that count, which gives a double flash once per period.
- R8: `rhythmOut[2]` equals bit RHYTHM_W-1 AND bit RHYTHM_W-4 of that count, which gives four flashes once per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eventIn | input | 1 | Event strobe, synchronous to clk and one cycle per event |
| ledOut | output | 1 | Stretched LED indication |
| rhythmOut | output | 3 | Blink patterns: bit 0 slow, bit 1 double flash, bit 2 four-flash strobe |

## Verification
The assertions assume that `eventIn` is already synchronous to `clk` and that reset is held for at least one edge before it is released. The bench drives events only at falling edges and asserts reset from time zero, so both assumptions hold. The properties are stated only one edge ahead. They cover the load on an event, the hold while idle, and the rollover to zero, so they stay valid for any counter width. The bench shrinks the stretch counter to 5 bits so that rollovers and wrap-edge events occur within a short run.

// File: rtl/ledPkg.sv
package ledPkg;
  localparam int NUM_PATTERNS = 3;

  typedef struct packed {
    logic load;
    logic advance;
  } stretchCtl_t;
endpackage

// File: rtl/stretchCtrl.sv
module stretchCtrl
  import ledPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        eventIn,
  input  logic        runBit,
  output stretchCtl_t ctl
);
  always_comb begin
    ctl.load    = eventIn;
    ctl.advance = runBit & ~eventIn;
  end

  AST_EVENT_LIGHTS: assert property (@(posedge clk) disable iff (rst)
    eventIn |=> runBit) else $error("event did not light LED"); // R2

  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    eventIn |-> !ctl.advance) else $error("advance with load"); // R5
endmodule

// File: rtl/stretchCount.sv
module stretchCount
  import ledPkg::*;
#(
  parameter int WIDTH = 21
) (
  input  logic        clk,
  input  logic        rst,
  input  stretchCtl_t ctl,
  output logic        runBit
);
  localparam logic [WIDTH-1:0] LOAD_VAL = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (ctl.load) begin
      count <= LOAD_VAL;
    end else if (ctl.advance) begin
      count <= count + 1'b1;
    end
  end

  assign runBit = count[WIDTH-1];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (count == '0)) else $error("counter not cleared"); // R1

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (count == LOAD_VAL)) else $error("bad load"); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!runBit && !ctl.load) |=> $stable(count)) else $error("idle drift"); // R3

  AST_WRAP_STOP: assert property (@(posedge clk) disable iff (rst)
    (count == ALL_ONES && !ctl.load) |=> (count == '0)) else $error("no wrap"); // R3
endmodule

// File: rtl/rhythmGen.sv
module rhythmGen
  import ledPkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [NUM_PATTERNS-1:0] pattern
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] freeCount;

  always_ff @(posedge clk) begin
    if (rst) freeCount <= '0;
    else     freeCount <= freeCount + 1'b1;
  end

  for (genvar i = 0; i < NUM_PATTERNS; i++) begin : g_tap
    localparam int LOW = (i == 0) ? TOP : TOP - 1 - i;
    assign pattern[i] = freeCount[TOP] & freeCount[LOW];
  end

  AST_DOUBLE_INSIDE: assert property (@(posedge clk) disable iff (rst)
    pattern[1] |-> pattern[0]) else $error("double outside slow"); // R7

  AST_STROBE_INSIDE: assert property (@(posedge clk) disable iff (rst)
    pattern[2] |-> pattern[0]) else $error("strobe outside slow"); // R8
endmodule

// File: rtl/ledPulseStretcher.sv
module ledPulseStretcher
  import ledPkg::*;
#(
  parameter int STRETCH_W = 21,
  parameter int RHYTHM_W  = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       eventIn,
  output logic       ledOut,
  output logic [2:0] rhythmOut
);
  stretchCtl_t ctl;
  logic        runBit;

  stretchCtrl u_ctrl (
    .clk(clk), .rst(rst), .eventIn(eventIn), .runBit(runBit), .ctl(ctl)
  );

  stretchCount #(.WIDTH(STRETCH_W)) u_count (
    .clk(clk), .rst(rst), .ctl(ctl), .runBit(runBit)
  );

  rhythmGen #(.WIDTH(RHYTHM_W)) u_rhythm (
    .clk(clk), .rst(rst), .pattern(rhythmOut)
  );

  assign ledOut = runBit;

  AST_RHYTHM_RESET: assert property (@(posedge clk)
    rst |=> (rhythmOut == '0)) else $error("rhythm not cleared"); // R1
endmodule

// File: tb/ledPulseStretcher_test.sv
`timescale 1ns/1ps
module ledPulseStretcher_test;
  localparam int SW  = 5;
  localparam int RW  = 6;
  localparam int LIT = 1 << (SW - 1);

  typedef struct {
    logic       expLed;
    logic [2:0] expRhy;
    string      ledTag;
    bit         inReset;
  } item_t;

  logic clk = 0;
  logic rst = 1;
  logic eventIn = 0;
  logic ledOut;
  logic [2:0] rhythmOut;

  int checks = 0;
  int failures = 0;
  int remaining = 0;
  int rhyCount = 0;
  bit done = 0;
  item_t q[$];

  ledPulseStretcher #(.STRETCH_W(SW), .RHYTHM_W(RW)) uut (
    .clk(clk), .rst(rst), .eventIn(eventIn), .ledOut(ledOut), .rhythmOut(rhythmOut)
  );

  always #4 clk = ~clk;

  task automatic driveCycle(input logic rstV, input logic ev, input string tag);
    item_t it;
    logic [RW-1:0] c;
    @(negedge clk);
    rst = rstV;
    eventIn = ev;
    if (rstV) begin
      remaining = 0;
      rhyCount = 0;
    end else begin
      if (ev) remaining = LIT;
      else if (remaining > 0) remaining--;
      rhyCount = (rhyCount + 1) % (1 << RW);
    end
    c = rhyCount[RW-1:0];
    it.expLed    = (remaining > 0);
    it.expRhy[0] = c[RW-1];
    it.expRhy[1] = c[RW-1] & c[RW-3];
    it.expRhy[2] = c[RW-1] & c[RW-4];
    it.ledTag    = tag;
    it.inReset   = rstV;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) driveCycle(1'b0, 1'b0, tag);
  endtask

  task automatic checkBit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checkBit(ledOut, it.expLed, it.ledTag);
        checkBit(rhythmOut[0], it.expRhy[0], it.inReset ? "R1" : "R6");
        checkBit(rhythmOut[1], it.expRhy[1], it.inReset ? "R1" : "R7");
        checkBit(rhythmOut[2], it.expRhy[2], it.inReset ? "R1" : "R8");
      end
    end
  end

  initial begin : stimulus
    for (int i = 0; i < 3; i++) driveCycle(1'b1, 1'b0, "R1");
    idle(1, "R1");
    idle(4, "R3");
    // single event, full interval then idle
    driveCycle(1'b0, 1'b1, "R2");
    idle(LIT - 1, "R2");
    idle(6, "R3");
    // retrigger mid-interval
    driveCycle(1'b0, 1'b1, "R2");
    idle(5, "R4");
    driveCycle(1'b0, 1'b1, "R4");
    idle(LIT + 3, "R4");
    // back-to-back events
    driveCycle(1'b0, 1'b1, "R4");
    driveCycle(1'b0, 1'b1, "R4");
    idle(LIT + 2, "R4");
    // event on the wrap edge
    driveCycle(1'b0, 1'b1, "R2");
    idle(LIT - 1, "R5");
    driveCycle(1'b0, 1'b1, "R5");
    idle(LIT + 4, "R5");
    // event on the first idle edge after an interval
    driveCycle(1'b0, 1'b1, "R2");
    idle(LIT, "R3");
    driveCycle(1'b0, 1'b1, "R2");
    idle(LIT + 30, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule